// File: doc/BRIEF.md
# Pin Event Detector

The block watches a bank of general-purpose input pins and turns selected transitions or levels on each pin into events. Every pin carries its own 4-bit mode code. The code does two jobs at once. It picks the condition to watch for: a rising edge, a falling edge, either edge, or a held low level. It also picks where the result goes: a per-pin DMA request for the edge modes, or the shared interrupt line for the level mode. Any code outside the defined set switches the pin off.

A detected event sets a sticky per-pin flag. A flag on a pin in interrupt (or disabled) mode is cleared by software, which writes a one to its bit in the collected status word. A flag on a pin in DMA mode is cleared by the per-pin transfer-done acknowledge. A low level that is still present when its flag is cleared sets the flag again one cycle later.

Pin inputs are asynchronous. Each one passes through a two-flop synchronizer, and edges are found by comparing the synchronized value with its value one cycle earlier. Software reaches the block through a single-cycle register port. The port has one word per pin for the mode code and one word that collects all the flags.

Top module: `pin_evt_detect`

## Requirements
- R1: After reset every mode code and every flag reads zero, `irq_o` is 0 and `dma_req_o` is all zeros.
- R2: Mode code 4'b0001 sets the pin's flag on a rising edge of the pin and on no falling edge. While the flag is set, that pin's `dma_req_o` bit is 1 and `irq_o` stays 0.
- R3: Mode code 4'b0010 sets the flag on a falling edge of the pin and on no rising edge.
- R4: Mode code 4'b0011 sets the flag on both rising and falling edges.
- R5: Mode code 4'b1000 sets the flag while the synchronized pin is 0, and `irq_o` is then 1.
- R6: Mode codes 4'b0000, the reserved 4'b0100 and every other unlisted code never set the flag, whatever the pin does.
- R7: In a mode other than 1, 2 or 3, a write of a one to a flag's bit in the status word clears that flag. Zero bits leave flags unchanged, and a flag otherwise stays set.
- R8: In modes 1, 2 and 3, a one on the pin's `dma_ack_i` bit clears the flag, and status-word writes have no effect on it. In other modes `dma_ack_i` has no effect.
- R9: Clearing has priority over detection in the same cycle. A mode-1000 flag cleared while the pin is still low reads 0 in the cycle after the clear and 1 again in the next cycle. It stays 0 if the pin has gone high.
- R10: A pin change applied before clock edge k shows in the flag after edge k+2. The path is two synchronizer stages plus one history register.
- R11: Register map (word addresses). Address n (0 to NUM_PINS-1) is pin n's word: bits [3:0] hold the mode code and are writable, and bit 8 reads the pin's flag. Address NUM_PINS is the status word: bit n is pin n's flag. Other addresses read 0. Reads are combinational.
- R12: `irq_o` is the OR of the flags of all pins in mode 1000. Bit n of `dma_req_o` equals pin n's flag while pin n is in mode 1, 2 or 3, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Combinational read data for `addr_i` |
| dma_ack_i | input | NUM_PINS | Per-pin transfer-done acknowledge |
| dma_req_o | output | NUM_PINS | Per-pin DMA request |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench drives each edge mode in both directions. A design that decoded the mode code wrongly would flag the opposite edge, or would miss the second edge in either-edge mode. The bench also times the third-edge latency exactly, so an extra or missing synchronizer stage shows up as an early or late flag.

It clears a low-level flag while the pin is still low and checks for the single zero cycle that follows. A design that let detection win over clearing would never show that cycle. A design without re-arming would leave the flag at zero.

It also crosses the two clear paths with the two kinds of mode, so a status write that wrongly clears a DMA flag, or an acknowledge that wrongly clears an interrupt flag, is caught. Finally, it toggles pins set to the reserved and unlisted codes to catch a decoder that treats them as live.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    EVT_OFF      = 4'b0000,
    EVT_DMA_RISE = 4'b0001,
    EVT_DMA_FALL = 4'b0010,
    EVT_DMA_BOTH = 4'b0011,
    EVT_RSVD     = 4'b0100,
    EVT_IRQ_LOW  = 4'b1000
  } evt_code_e;

  function automatic logic code_is_dma(input logic [CODE_W-1:0] c);
    return (c == EVT_DMA_RISE) || (c == EVT_DMA_FALL) || (c == EVT_DMA_BOTH);
  endfunction

  function automatic logic code_is_irq(input logic [CODE_W-1:0] c);
    return c == EVT_IRQ_LOW;
  endfunction
endpackage

// File: rtl/pin_evt_sync.sv
module pin_evt_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
  import pin_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_s_i,
  input  logic              cfg_we_i,
  input  logic [CODE_W-1:0] cfg_wdata_i,
  input  logic              w1c_i,
  input  logic              ack_i,
  output logic [CODE_W-1:0] code_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              dma_o
);
  logic [CODE_W-1:0] code_q;
  logic prev_q, flag_q;
  logic rise, fall, evt, dma_mode, irq_mode, clr;

  always_comb begin
    rise = pin_s_i & ~prev_q;
    fall = ~pin_s_i & prev_q;
    case (code_q)
      EVT_DMA_RISE: evt = rise;
      EVT_DMA_FALL: evt = fall;
      EVT_DMA_BOTH: evt = rise | fall;
      EVT_IRQ_LOW:  evt = ~pin_s_i;
      default:      evt = 1'b0;
    endcase
  end

  assign dma_mode = code_is_dma(code_q);
  assign irq_mode = code_is_irq(code_q);
  // clear wins over a same-cycle event; a live level re-sets next cycle
  assign clr = dma_mode ? ack_i : w1c_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (cfg_we_i) code_q <= cfg_wdata_i;
      if (clr)      flag_q <= 1'b0;
      else if (evt) flag_q <= 1'b1;
    end
  end

  assign code_o = code_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_mode;
  assign dma_o  = flag_q & dma_mode;
endmodule

// File: rtl/pin_evt_regif.sv
module pin_evt_regif
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int FLAG_BIT = 8
) (
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic [NUM_PINS-1:0][CODE_W-1:0]  code_i,
  input  logic [NUM_PINS-1:0]              flag_i,
  output logic [NUM_PINS-1:0]              cfg_we_o,
  output logic [CODE_W-1:0]                cfg_wdata_o,
  output logic [NUM_PINS-1:0]              w1c_o,
  output logic [DATA_W-1:0]                rd_data_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

  logic stat_sel;
  assign stat_sel    = (addr_i == STAT_ADDR);
  assign cfg_wdata_o = wr_data_i[CODE_W-1:0];
  assign w1c_o       = (wr_en_i && stat_sel) ? wr_data_i[NUM_PINS-1:0] : '0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_we
    assign cfg_we_o[p] = wr_en_i && (addr_i == ADDR_W'(p));
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(p)) begin
        rd_data_o[CODE_W-1:0] = code_i[p];
        rd_data_o[FLAG_BIT]   = flag_i[p];
      end
    end
    if (stat_sel) rd_data_o[NUM_PINS-1:0] = flag_i;
  end
endmodule

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_evt_pkg::*;
#(
  parameter  int NUM_PINS    = 32,
  parameter  int DATA_W      = 32,
  parameter  int SYNC_STAGES = 2,
  parameter  int FLAG_BIT    = 8,
  localparam int ADDR_W      = $clog2(NUM_PINS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_PINS-1:0] dma_ack_i,
  output logic [NUM_PINS-1:0] dma_req_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]             pin_s;
  logic [NUM_PINS-1:0][CODE_W-1:0] code_vec;
  logic [NUM_PINS-1:0]             flag_vec, irq_vec, cfg_we, w1c;
  logic [CODE_W-1:0]               cfg_wdata;

  pin_evt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  pin_evt_regif #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
  ) regif_i (
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wr_data_i  (wr_data_i),
    .code_i     (code_vec),
    .flag_i     (flag_vec),
    .cfg_we_o   (cfg_we),
    .cfg_wdata_o(cfg_wdata),
    .w1c_o      (w1c),
    .rd_data_o  (rd_data_o)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_evt_cell cell_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_s_i    (pin_s[p]),
      .cfg_we_i   (cfg_we[p]),
      .cfg_wdata_i(cfg_wdata),
      .w1c_i      (w1c[p]),
      .ack_i      (dma_ack_i[p]),
      .code_o     (code_vec[p]),
      .flag_o     (flag_vec[p]),
      .irq_o      (irq_vec[p]),
      .dma_o      (dma_req_o[p])
    );
  end

  assign irq_o = |irq_vec;
endmodule

// File: rtl/pin_evt_detect_chk.sv
module pin_evt_detect_chk
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [DATA_W-1:0]               wr_data_i,
  input logic [NUM_PINS-1:0]             dma_ack_i,
  input logic [NUM_PINS-1:0]             dma_req_o,
  input logic                            irq_o,
  input logic [NUM_PINS-1:0]             flag_i,
  input logic [NUM_PINS-1:0][CODE_W-1:0] code_i
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (addr_i == ADDR_W'(NUM_PINS));

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (flag_i == '0 && dma_req_o == '0 && !irq_o));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic sw_clr, hw_clr;
    assign sw_clr = stat_wr && wr_data_i[p] && !code_is_dma(code_i[p]);
    assign hw_clr = dma_ack_i[p] && code_is_dma(code_i[p]);

    assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_clr |=> !flag_i[p]);
    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_i[p] && !sw_clr && !hw_clr) |=> flag_i[p]);
    assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_clr |=> !flag_i[p]);
    assert_no_evt_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[p]) |-> $past(code_is_dma(code_i[p]) || code_is_irq(code_i[p])));
    assert_dma_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[p] |-> (flag_i[p] && code_is_dma(code_i[p])));
  end
endmodule

bind pin_evt_detect pin_evt_detect_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wr_data_i(wr_data_i),
  .dma_ack_i(dma_ack_i),
  .dma_req_o(dma_req_o),
  .irq_o    (irq_o),
  .flag_i   (flag_vec),
  .code_i   (code_vec)
);

// File: tb/pin_evt_detect_tb_top.sv
module pin_evt_detect_tb_top;
  localparam int CLK_P  = 10;
  localparam int NP     = 32;
  localparam int DW     = 32;
  localparam int AW     = $clog2(NP + 1);
  localparam int STAT   = NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] ack = '0;
  logic [NP-1:0] dma_req;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_evt_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .dma_ack_i(ack),
    .dma_req_o(dma_req), .irq_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic flag_of(input int p, output logic f);
    logic [31:0] s;
    rd(STAT, s);
    f = s[p];
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    pin[p] = v;
  endtask

  task automatic pulse_ack(input int p);
    @(negedge clk); ack[p] = 1'b1;
    @(negedge clk); ack[p] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);    chk("R1", "pin0 word", d, 0);
    rd(31, d);   chk("R1", "pin31 word", d, 0);
    rd(STAT, d); chk("R1", "status", d, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "dma_req", dma_req, 0);
  endtask

  task automatic t_rise();
    logic f; logic [31:0] d;
    wr(3, 32'h1);
    set_pin(3, 1'b1);
    cyc(2); flag_of(3, f); chk("R10", "flag before third edge", {31'b0, f}, 0);
    cyc(1); flag_of(3, f); chk("R10", "flag after third edge", {31'b0, f}, 1);
    chk("R2", "dma_req bit3", {31'b0, dma_req[3]}, 1);
    chk("R2", "irq stays low", {31'b0, irq}, 0);
    rd(3, d); chk("R11", "pin3 word code+flag", d, 32'h101);
    pulse_ack(3); flag_of(3, f); chk("R8", "ack clears rise flag", {31'b0, f}, 0);
    set_pin(3, 1'b0); cyc(4); flag_of(3, f);
    chk("R2", "falling edge ignored", {31'b0, f}, 0);
    wr(3, 32'h0);
  endtask

  task automatic t_fall();
    logic f;
    wr(5, 32'h2);
    set_pin(5, 1'b1); cyc(4); flag_of(5, f);
    chk("R3", "rising edge ignored", {31'b0, f}, 0);
    set_pin(5, 1'b0); cyc(3); flag_of(5, f);
    chk("R3", "falling edge sets", {31'b0, f}, 1);
    chk("R3", "dma_req bit5", {31'b0, dma_req[5]}, 1);
    pulse_ack(5); flag_of(5, f); chk("R8", "ack clears fall flag", {31'b0, f}, 0);
    wr(5, 32'h0);
  endtask

  task automatic t_both();
    logic f;
    wr(7, 32'h3);
    set_pin(7, 1'b1); cyc(3); flag_of(7, f);
    chk("R4", "rise sets", {31'b0, f}, 1);
    pulse_ack(7); flag_of(7, f); chk("R4", "ack cleared", {31'b0, f}, 0);
    set_pin(7, 1'b0); cyc(3); flag_of(7, f);
    chk("R4", "fall sets", {31'b0, f}, 1);
    wr(STAT, 32'h1 << 7); flag_of(7, f);
    chk("R8", "status write ignored in DMA mode", {31'b0, f}, 1);
    pulse_ack(7); flag_of(7, f); chk("R8", "ack clears both flag", {31'b0, f}, 0);
    wr(7, 32'h0);
  endtask

  task automatic t_level();
    logic f;
    wr(10, 32'h8);
    cyc(1); flag_of(10, f); chk("R5", "low level sets", {31'b0, f}, 1);
    chk("R5", "irq high", {31'b0, irq}, 1);
    chk("R12", "no dma_req in irq mode", {31'b0, dma_req[10]}, 0);
    wr(STAT, 32'h1 << 10); flag_of(10, f);
    chk("R9", "zero cycle after clear", {31'b0, f}, 0);
    cyc(1); flag_of(10, f); chk("R9", "re-set while low", {31'b0, f}, 1);
    set_pin(10, 1'b1); cyc(3);
    wr(STAT, 32'h0); flag_of(10, f);
    chk("R7", "zero write no effect", {31'b0, f}, 1);
    wr(STAT, 32'h1 << 10); cyc(3); flag_of(10, f);
    chk("R9", "stays clear once high", {31'b0, f}, 0);
    chk("R7", "irq low after clear", {31'b0, irq}, 0);
    set_pin(10, 1'b0); cyc(3);
    pulse_ack(10); flag_of(10, f);
    chk("R8", "ack ignored in irq mode", {31'b0, f}, 1);
    set_pin(10, 1'b1); cyc(3);
    wr(STAT, 32'h1 << 10);
    wr(10, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(12, 32'h0); wr(13, 32'h4); wr(14, 32'h5); wr(15, 32'hF);
    @(negedge clk); pin[15:12] = 4'hF; cyc(4);
    rd(STAT, d); chk("R6", "off codes ignore rise", d & 32'h0000_F000, 0);
    @(negedge clk); pin[15:12] = 4'h0; cyc(4);
    rd(STAT, d); chk("R6", "off codes ignore fall/low", d & 32'h0000_F000, 0);
    chk("R6", "irq low", {31'b0, irq}, 0);
    chk("R6", "dma_req low", dma_req, 0);
    wr(13, 32'h0); wr(14, 32'h0); wr(15, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(20, 32'hFFFF_FFF3); rd(20, d);
    chk("R11", "only code bits stored", d, 32'h3);
    rd(STAT + 1, d); chk("R11", "unmapped reads zero", d, 0);
    wr(20, 32'h0); rd(20, d);
    chk("R11", "code rewritten", d, 0);
  endtask

  task automatic t_irq_or();
    logic [31:0] d;
    wr(20, 32'h8); wr(21, 32'h8);
    cyc(1); rd(STAT, d);
    chk("R12", "two level flags", d & 32'h0030_0000, 32'h0030_0000);
    set_pin(20, 1'b1); cyc(3); wr(STAT, 32'h1 << 20);
    chk("R12", "irq held by other pin", {31'b0, irq}, 1);
    set_pin(21, 1'b1); cyc(3); wr(STAT, 32'h1 << 21);
    chk("R12", "irq drops with last flag", {31'b0, irq}, 0);
    wr(22, 32'h1); set_pin(22, 1'b1); cyc(3);
    chk("R12", "dma flag not on irq", {31'b0, irq}, 0);
    chk("R12", "dma_req bit22 only", dma_req, 32'h1 << 22);
    pulse_ack(22);
    chk("R12", "dma_req cleared", dma_req, 0);
    wr(20, 32'h0); wr(21, 32'h0); wr(22, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_disabled();
    t_regmap();
    t_irq_or();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule